// File: doc/BRIEF.md
# Interrupt and Timer Event Spawner

This block starts new threads on a set of processing engines in response to three kinds of event: the end of hardware reset, external interrupt lines and a match of a free-running cycle timer. Each event is latched. The block then picks one pending event, requests one or more engines from an interconnect arbiter, and waits for a grant. It then delivers a two-beat context payload to the granted engine, with valid and last flags and a ready handshake.

Each interrupt line has its own mask bit and its own steering setting. In open steering, the block requests every engine and takes whichever grants first. In fixed steering, only the configured engine is requested. The timer event always goes to its own configured engine. The reset event always goes to engine 0.

Top module: `evt_spawner`

## Requirements
- R1: While `rst_n` is low, `req_o` is all zeros and `pl_valid_o` is low.
- R2: After reset is released, one reset event (event code 0) is spawned on engine 0 without any other stimulus.
- R3: An interrupt line whose bit in `cfg_irq_mask` is 1 is ignored. No request and no payload result from it.
- R4: For an interrupt whose `cfg_irq_any` bit is 1, `req_o` is all ones. In the cycle after any requested bit is granted, `req_o` returns to zero, and the payload goes to the lowest granted engine, reported on `pl_dst_o`.
- R5: For an interrupt in fixed steering, and for the timer and reset events, `req_o` has exactly one bit set: the configured engine. It holds that value until it is granted.
- R6: A 32-bit timer starts at 0 when reset is released and increments every cycle. When it equals `cfg_tmr_cmp`, a timer event (code 1) is spawned on engine `cfg_tmr_eng`.
- R7: Pending events are served one at a time, with the lowest event code first. Event codes are 0 for reset, 1 for timer and 2+k for interrupt line k.
- R8: The payload is two beats. The first beat carries the event's start address from slice e of `cfg_vec` (bits e*64 to e*64+63) with last low. The second beat carries the event code, zero-extended, with last high.
- R9: While `pl_valid_o` is high and `pl_ready_i` is low, the data, last and destination outputs hold steady.
- R10: An event stays pending until its last beat is accepted. Events that arrive while another event is being served are not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 4 | External interrupt lines, sampled each cycle |
| cfg_irq_mask | input | 4 | 1 blocks the matching interrupt line |
| cfg_irq_any | input | 4 | 1 selects open steering for the line, 0 selects fixed steering |
| cfg_irq_eng | input | 12 | Target engine per line, 3 bits per line, line k at bits 3k+2..3k |
| cfg_tmr_cmp | input | 32 | Timer compare value |
| cfg_tmr_eng | input | 3 | Target engine of the timer event |
| cfg_vec | input | 384 | Start address per event code, 64 bits each |
| req_o | output | 8 | Per-engine spawn request |
| gnt_i | input | 8 | Per-engine grant from the arbiter |
| pl_valid_o | output | 1 | Payload beat valid |
| pl_data_o | output | 64 | Payload beat data |
| pl_last_o | output | 1 | Marks the final payload beat |
| pl_dst_o | output | 3 | Engine receiving the payload |
| pl_ready_i | input | 1 | Payload beat accepted when high with valid |

## Verification
The assertions assume that the arbiter grants only engines that are currently requested, and that it never grants while no request is raised. The bench derives each grant from the current `req_o` masked by its chosen engine set, so this holds. The assertions also assume the configuration stays fixed while an event is being served. The bench changes masks, steering and the compare value only when nothing is pending. It never raises an interrupt again while that same interrupt is still being served.

// File: rtl/evt_spawner.sv
module evt_spawner #(
  parameter int NUM_ENG = 8,
  parameter int NUM_IRQ = 4,
  parameter int TMR_W   = 32,
  parameter int DATA_W  = 64,
  localparam int EGW = $clog2(NUM_ENG),
  localparam int NEV = NUM_IRQ + 2,
  localparam int EVW = $clog2(NEV)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_IRQ-1:0]     irq_i,
  input  logic [NUM_IRQ-1:0]     cfg_irq_mask,
  input  logic [NUM_IRQ-1:0]     cfg_irq_any,
  input  logic [NUM_IRQ*EGW-1:0] cfg_irq_eng,
  input  logic [TMR_W-1:0]       cfg_tmr_cmp,
  input  logic [EGW-1:0]         cfg_tmr_eng,
  input  logic [NEV*DATA_W-1:0]  cfg_vec,
  output logic [NUM_ENG-1:0]     req_o,
  input  logic [NUM_ENG-1:0]     gnt_i,
  output logic                   pl_valid_o,
  output logic [DATA_W-1:0]      pl_data_o,
  output logic                   pl_last_o,
  output logic [EGW-1:0]         pl_dst_o,
  input  logic                   pl_ready_i
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_ADDR, S_CODE} st_t;

  st_t               st;
  logic [TMR_W-1:0]  tmr;
  logic [NEV-1:0]    pend, set_v, clr_v;
  logic [EVW-1:0]    cur, pick;
  logic [EGW-1:0]    dst, cur_eng, gpick;
  logic              cur_any;
  logic [DATA_W-1:0] vec_sel;
  logic [NUM_ENG-1:0] hitv;

  assign set_v = {irq_i & ~cfg_irq_mask, tmr == cfg_tmr_cmp, 1'b0};
  assign clr_v = (st == S_CODE && pl_ready_i) ? (NEV'(1) << cur) : '0;

  always_comb begin
    pick = '0;
    for (int i = NEV - 1; i >= 0; i--)
      if (pend[i]) pick = EVW'(i);
  end

  always_comb begin
    cur_any = 1'b0;
    cur_eng = (cur == EVW'(1)) ? cfg_tmr_eng : '0;
    for (int k = 0; k < NUM_IRQ; k++)
      if (cur == EVW'(k + 2)) begin
        cur_any = cfg_irq_any[k];
        cur_eng = cfg_irq_eng[k*EGW +: EGW];
      end
    vec_sel = '0;
    for (int e = 0; e < NEV; e++)
      if (cur == EVW'(e)) vec_sel = cfg_vec[e*DATA_W +: DATA_W];
  end

  assign req_o = (st != S_REQ) ? '0 : (cur_any ? '1 : (NUM_ENG'(1) << cur_eng));
  assign hitv  = req_o & gnt_i;

  always_comb begin
    gpick = '0;
    for (int i = NUM_ENG - 1; i >= 0; i--)
      if (hitv[i]) gpick = EGW'(i);
  end

  assign pl_valid_o = (st == S_ADDR) || (st == S_CODE);
  assign pl_last_o  = (st == S_CODE);
  assign pl_data_o  = (st == S_CODE) ? DATA_W'(cur) : vec_sel;
  assign pl_dst_o   = dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tmr  <= '0;
      pend <= NEV'(1);
      cur  <= '0;
      dst  <= '0;
    end else begin
      tmr  <= tmr + 1'b1;
      pend <= (pend & ~clr_v) | set_v;
      case (st)
        S_IDLE: if (|pend) begin
          cur <= pick;
          st  <= S_REQ;
        end
        S_REQ: if (|hitv) begin
          dst <= gpick;
          st  <= S_ADDR;
        end
        S_ADDR: if (pl_ready_i) st <= S_CODE;
        S_CODE: if (pl_ready_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evt_spawner_chk.sv
module evt_spawner_chk #(
  parameter int NUM_ENG = 8,
  parameter int DATA_W  = 64,
  localparam int EGW = $clog2(NUM_ENG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_ENG-1:0] req_o,
  input logic [NUM_ENG-1:0] gnt_i,
  input logic               pl_valid_o,
  input logic [DATA_W-1:0]  pl_data_o,
  input logic               pl_last_o,
  input logic [EGW-1:0]     pl_dst_o,
  input logic               pl_ready_i
);

  always_comb if (!rst_n) AST_IDLE_IN_RESET: assert (req_o == '0); // R1

  AST_REQ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o != '0) |-> ($countones(req_o) == 1 || req_o == '1)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o != '0 && (req_o & gnt_i) == '0) |=> $stable(req_o)); // R5

  AST_DROP_ON_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_o & gnt_i) != '0) |=> (req_o == '0 && pl_valid_o)); // R4

  AST_NO_REQ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid_o |-> (req_o == '0)); // R4

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid_o && !pl_ready_i) |=> (pl_valid_o && $stable(pl_data_o)
      && $stable(pl_last_o) && $stable(pl_dst_o))); // R9

  AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid_o && pl_ready_i && !pl_last_o) |=> (pl_valid_o && pl_last_o)); // R8

  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid_o && pl_ready_i && pl_last_o) |=> !pl_valid_o); // R8

endmodule

bind evt_spawner evt_spawner_chk #(.NUM_ENG(NUM_ENG), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_o(req_o), .gnt_i(gnt_i),
  .pl_valid_o(pl_valid_o), .pl_data_o(pl_data_o), .pl_last_o(pl_last_o),
  .pl_dst_o(pl_dst_o), .pl_ready_i(pl_ready_i)
);

// File: tb/evt_spawner_tb_top.sv
`timescale 1ns/1ps
module evt_spawner_tb_top;
  localparam int NE = 8, NI = 4, DW = 64, NEV = 6;

  logic clk = 0, rst_n = 0;
  logic [NI-1:0] irq_i = '0, cfg_irq_mask, cfg_irq_any;
  logic [NI*3-1:0] cfg_irq_eng;
  logic [31:0] cfg_tmr_cmp;
  logic [2:0] cfg_tmr_eng;
  logic [NEV*DW-1:0] cfg_vec;
  logic [NE-1:0] req_o, gnt_i = '0;
  logic pl_valid_o, pl_last_o, pl_ready_i = 0;
  logic [DW-1:0] pl_data_o;
  logic [2:0] pl_dst_o;

  int checks = 0, errors = 0, ncyc = 0;
  logic gnt_en = 0, bp_on = 1, beat0_seen = 0;
  logic [NE-1:0] gnt_mask = '1;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  evt_spawner dut_i (.*);

  function automatic logic [DW-1:0] vec_of(int e);
    return 64'h1000_0000_0000_0040 + 64'(e) * 64'h100;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_spawn(int ev, int eng);
    exp_q.push_back({8'(ev), 8'(eng)});
  endtask

  task automatic pulse_irq(int k);
    @(negedge clk); irq_i[k] = 1'b1;
    @(negedge clk); irq_i[k] = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !pl_valid_o && req_o == '0) break;
    end
    chk(exp_q.size() == 0, "R10 drain", 64'(exp_q.size()), 0);
  endtask

  // driver of grant and ready, plus monitor of payload beats
  always @(negedge clk) begin
    ncyc++;
    pl_ready_i = bp_on ? (ncyc % 3 != 0) : 1'b1;
    gnt_i = gnt_en ? (req_o & gnt_mask) : '0;
    if (rst_n && pl_valid_o && pl_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3 R10 unexpected beat", pl_data_o, 0);
      end else if (!beat0_seen) begin
        chk(pl_last_o == 0, "R8 first beat last", pl_last_o, 0);
        chk(pl_data_o == vec_of(int'(exp_q[0][15:8])), "R8 start address", pl_data_o,
            vec_of(int'(exp_q[0][15:8])));
        chk(pl_dst_o == exp_q[0][2:0], "R4 R5 destination", pl_dst_o, exp_q[0][2:0]);
        beat0_seen = 1;
      end else begin
        chk(pl_last_o == 1, "R8 second beat last", pl_last_o, 1);
        chk(pl_data_o == 64'(exp_q[0][15:8]), "R7 R8 event code", pl_data_o, exp_q[0][15:8]);
        void'(exp_q.pop_front());
        beat0_seen = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual timeout expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg_irq_mask = 4'b0100;
    cfg_irq_any  = 4'b0010;
    cfg_irq_eng  = {3'd6, 3'd1, 3'd0, 3'd3};
    cfg_tmr_cmp  = 32'd5;
    cfg_tmr_eng  = 3'd2;
    for (int e = 0; e < NEV; e++) cfg_vec[e*DW +: DW] = vec_of(e);
    repeat (4) @(negedge clk);
    chk(req_o == '0, "R1 req in reset", req_o, 0);
    chk(pl_valid_o == 0, "R1 valid in reset", pl_valid_o, 0);
    rst_n = 1;

    // R2 R6 R7: reset, timer and two lines pile up while grants are withheld
    repeat (2) @(negedge clk);
    chk(req_o == 8'h01, "R2 reset event requests engine 0", req_o, 8'h01);
    irq_i = 4'b1101;
    @(negedge clk); irq_i = '0;
    repeat (10) @(negedge clk);
    chk(req_o == 8'h01, "R5 request held without grant", req_o, 8'h01);
    expect_spawn(0, 0);
    expect_spawn(1, 2);
    expect_spawn(2, 3);
    expect_spawn(5, 6);
    gnt_en = 1;
    drain();

    // R5: fixed steering on line 3
    gnt_en = 0;
    pulse_irq(3);
    repeat (3) @(negedge clk);
    chk(req_o == 8'h40, "R5 fixed request", req_o, 8'h40);
    expect_spawn(5, 6);
    gnt_en = 1;
    drain();

    // R4: open steering on line 1, arbiter picks engine 5
    gnt_en = 0;
    gnt_mask = 8'h20;
    pulse_irq(1);
    repeat (3) @(negedge clk);
    chk(req_o == 8'hFF, "R4 open request", req_o, 8'hFF);
    expect_spawn(3, 5);
    gnt_en = 1;
    for (int i = 0; i < 20 && !pl_valid_o; i++) @(negedge clk);
    chk(req_o == '0, "R4 requests dropped after grant", req_o, 0);
    drain();
    gnt_mask = '1;

    // R3: masked line 2 leaves no trace, then unmasked line 2 spawns
    pulse_irq(2);
    repeat (20) @(negedge clk);
    chk(req_o == '0 && !pl_valid_o, "R3 masked line ignored", req_o, 0);
    cfg_irq_mask = 4'b0001;
    pulse_irq(2);
    expect_spawn(4, 1);
    drain();
    pulse_irq(0);
    repeat (20) @(negedge clk);
    chk(req_o == '0 && !pl_valid_o, "R3 masked line 0 ignored", req_o, 0);

    // R6: second timer match, far ahead of the current count
    cfg_tmr_eng = 3'd7;
    cfg_tmr_cmp = 32'(ncyc + 40);
    expect_spawn(1, 7);
    repeat (20) @(negedge clk);
    chk(req_o == '0, "R6 no spawn before match", req_o, 0);
    drain();

    // R9 R10: no backpressure, back-to-back lines 1 and 3
    bp_on = 0;
    cfg_irq_any = '0;
    irq_i = 4'b1010;
    @(negedge clk); irq_i = '0;
    expect_spawn(3, 0);
    expect_spawn(5, 6);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule